// File: doc/BRIEF.md
# Converter Configuration Serial Port

This block is the configuration port of a dual-channel data converter. A host drives a three-wire serial link: a serial clock, an active-low select and one data line that the block reads during writes and drives during reads. The bus signals are brought into the block's own clock domain through synchronizers. Each frame opens with a 16-bit instruction and continues with one or more data bytes. Those bytes go to or come from a small register file, which drives the control outputs of the converter datapath.

The program registers (power mode, clock stabilizer, test pattern and self-test) are double-buffered. Host writes land in a shadow copy, and the datapath outputs follow only when a transfer command copies every shadow register to the active set in one cycle. The test-pattern and self-test registers exist once per channel. A channel-select register steers writes to one or both copies and decides which copy a read returns. Identification registers are read-only. A soft-reset bit restores every register. The serial link has no back-pressure: the host owns the clock, and every byte is taken or supplied on the edges the host provides.

Top module: `conv_cfg_spi`

## Requirements
- R1: A frame begins at the first serial-clock rising edge after select falls. The 16-bit instruction carries, in arrival order for MSB-first mode, the read flag (1 = read), a two-bit length code and a 13-bit address.
- R2: Length code 00, 01 or 10 means 1, 2 or 3 data bytes, after which the next rising edge starts a new instruction. Code 11 streams bytes until select rises.
- R3: When select rises between bytes of a counted frame, the transfer stalls and resumes when select falls again. When select rises in mid-byte, in mid-instruction or during a streamed frame, the frame is abandoned and nothing partial is written.
- R4: During the data phase of a read, with select low, sdio_oe is 1. The block samples data on rising edges and updates sdio_out after falling edges. sdio_oe is 0 at all other times, and a read frame never writes.
- R5: In a multi-byte frame the address steps down by one after each byte in MSB-first mode and steps up by one in LSB-first mode.
- R6: In register 0x00, bit 6 or bit 1 selects LSB-first order for both instruction and data. A read of 0x00 returns the setting mirrored in both bits, with bits 4 and 3 fixed at 1, so the value is 0x18 or 0x5A.
- R7: Registers 0x08, 0x09, 0x0D and 0x0E are shadowed. The outputs change only when 0x01 is written to 0xFF. That write copies all of them in the same cycle, and 0xFF reads back 0x00.
- R8: Register 0x05 selects channels: bit 0 = A, bit 1 = B, default 0x03. A write to 0x0D or 0x0E updates every selected channel. A read returns A's copy when bit 0 is set, B's copy when only bit 1 is set, and 0x00 when neither is set.
- R9: Address 0x01 always reads 0x0A and address 0x02 always reads 0x00. Writes to either have no effect.
- R10: Defaults are 0x00 for 0x08, 0x0D and 0x0E, and 0x01 for 0x09. Unused bits are stored as 0, using masks 0x03 (0x08), 0x01 (0x09), 0x37 (0x0D) and 0x05 (0x0E).
- R11: Writing 0x00 with bit 5 or bit 2 set restores every register (shadow, active, channel select, bit order) to its default. The reset bit reads back as 0.
- R12: Any address not listed above reads 0x00, and writes to it are ignored.
- R13: Registers 0x08 and 0x09 are global: writes to them take effect whatever channel selection is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; it oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| csb | input | 1 | Active-low frame select |
| sdio_in | input | 1 | Serial data from the host |
| sdio_out | output | 1 | Serial read data to the host |
| sdio_oe | output | 1 | Drive enable for the shared data line |
| pwr_mode | output | 2 | Active power mode |
| dcs_en | output | 1 | Active clock duty-cycle stabilizer enable |
| test_cfg | output | 8*NUM_CH | Active test-pattern settings; channel A in the low byte |
| bist_cfg | output | 8*NUM_CH | Active self-test settings; channel A in the low byte |

## Verification
The hardest state to reach from the pins is a frame paused with select high at a byte boundary. In that state the decision between stall and abandon rests on internal counters that no output shows. The bench reaches it by raising select after a whole byte of a two-byte write, and again after four bits of a one-byte write. Later reads of both target addresses then reveal which bytes were committed. Mirrored bit order is reached by a write in MSB order that switches the port to LSB order. After that switch the bench reverses its own bit order and exercises incrementing multi-byte access and the soft reset.

// File: rtl/conv_cfg_pkg.sv
package conv_cfg_pkg;
  localparam logic [15:0] A_CFG   = 16'h0000;
  localparam logic [15:0] A_ID    = 16'h0001;
  localparam logic [15:0] A_GRADE = 16'h0002;
  localparam logic [15:0] A_INDEX = 16'h0005;
  localparam logic [15:0] A_MODES = 16'h0008;
  localparam logic [15:0] A_CLOCK = 16'h0009;
  localparam logic [15:0] A_TEST  = 16'h000D;
  localparam logic [15:0] A_BIST  = 16'h000E;
  localparam logic [15:0] A_XFER  = 16'h00FF;

  localparam logic [7:0] ID_VALUE  = 8'h0A;
  localparam logic [7:0] TEST_MASK = 8'h37;
  localparam logic [7:0] BIST_MASK = 8'h05;

  typedef enum logic {PH_INSTR, PH_DATA} phase_t;
endpackage

// File: rtl/conv_cfg_sync.sv
module conv_cfg_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/conv_cfg_frame.sv
module conv_cfg_frame
  import conv_cfg_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              csb_s,
  input  logic              sdi_s,
  input  logic              lsb_first,
  input  logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              sdo,
  output logic              sdo_oe
);
  localparam int IW = ADDR_W + 3;
  localparam int CW = $clog2(IW);

  phase_t            phase;
  logic [CW-1:0]     bit_cnt;
  logic [IW-1:0]     sh, nxt_sh;
  logic              sclk_q, csb_q, is_read, stream;
  logic [1:0]        left;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        tx, rx_byte;
  logic              rise, fall, csb_up;

  function automatic logic pick(input logic [7:0] v, input logic [2:0] k, input logic lsb);
    return lsb ? v[k] : v[3'd7 - k];
  endfunction

  assign rise    = sclk_s & ~sclk_q & ~csb_s;
  assign fall    = ~sclk_s & sclk_q & ~csb_s;
  assign csb_up  = csb_s & ~csb_q;
  assign nxt_sh  = lsb_first ? {sdi_s, sh[IW-1:1]} : {sh[IW-2:0], sdi_s};
  assign rx_byte = lsb_first ? nxt_sh[IW-1:IW-8] : nxt_sh[7:0];
  assign rd_addr = addr;
  assign sdo_oe  = (phase == PH_DATA) && is_read && !csb_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_INSTR;
      bit_cnt <= '0;
      sh      <= '0;
      sclk_q  <= 1'b0;
      csb_q   <= 1'b1;
      is_read <= 1'b0;
      stream  <= 1'b0;
      left    <= '0;
      addr    <= '0;
      tx      <= '0;
      sdo     <= 1'b0;
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      sclk_q <= sclk_s;
      csb_q  <= csb_s;
      wr_stb <= 1'b0;
      if (csb_up) begin
        // a clean byte boundary in a counted frame only pauses
        if (phase == PH_INSTR || bit_cnt != '0 || stream) begin
          phase   <= PH_INSTR;
          bit_cnt <= '0;
        end
      end else if (rise) begin
        sh <= nxt_sh;
        if (phase == PH_INSTR) begin
          if (bit_cnt == CW'(IW-1)) begin
            is_read <= nxt_sh[IW-1];
            left    <= nxt_sh[IW-2:IW-3];
            stream  <= (nxt_sh[IW-2:IW-3] == 2'b11);
            addr    <= nxt_sh[ADDR_W-1:0];
            phase   <= PH_DATA;
            bit_cnt <= '0;
          end else begin
            bit_cnt <= bit_cnt + CW'(1);
          end
        end else if (bit_cnt == CW'(7)) begin
          bit_cnt <= '0;
          if (!is_read) begin
            wr_stb  <= 1'b1;
            wr_addr <= addr;
            wr_data <= rx_byte;
          end
          addr <= lsb_first ? addr + ADDR_W'(1) : addr - ADDR_W'(1);
          if (!stream) begin
            if (left == 2'd0) phase <= PH_INSTR;
            else              left  <= left - 2'd1;
          end
        end else begin
          bit_cnt <= bit_cnt + CW'(1);
        end
      end else if (fall && phase == PH_DATA && is_read) begin
        if (bit_cnt == '0) begin
          tx  <= rd_data;
          sdo <= pick(rd_data, 3'd0, lsb_first);
        end else begin
          sdo <= pick(tx, bit_cnt[2:0], lsb_first);
        end
      end
    end
  end

  // R2: a data byte never counts past its eighth bit
  p_data_cnt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DATA) |-> (bit_cnt < CW'(8)));

  // R5: address step after each completed byte follows the bit order
  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !csb_up && phase == PH_DATA && bit_cnt == CW'(7)) |=>
      (addr == ($past(lsb_first) ? $past(addr) + ADDR_W'(1) : $past(addr) - ADDR_W'(1))));

  // R4: a read frame never issues a register write
  p_no_wr_in_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> !is_read);
endmodule

// File: rtl/conv_cfg_regs.sv
module conv_cfg_regs
  import conv_cfg_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 13
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_stb,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [7:0]          wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [7:0]          rd_data,
  output logic                lsb_first,
  output logic [1:0]          pwr_mode,
  output logic                dcs_en,
  output logic [8*NUM_CH-1:0] test_cfg,
  output logic [8*NUM_CH-1:0] bist_cfg
);
  localparam int SW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [NUM_CH-1:0] index;
  logic [1:0]        sh_modes, act_modes;
  logic              sh_clk, act_clk;
  logic [7:0]        sh_test [NUM_CH];
  logic [7:0]        sh_bist [NUM_CH];
  logic [7:0]        act_test [NUM_CH];
  logic [7:0]        act_bist [NUM_CH];
  logic              clr, xfer, found;
  logic [SW-1:0]     sel;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [15:0] c);
    return a == c[ADDR_W-1:0];
  endfunction

  assign clr  = wr_stb && hit(wr_addr, A_CFG) && (wr_data[5] || wr_data[2]);
  assign xfer = wr_stb && hit(wr_addr, A_XFER) && wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lsb_first <= 1'b0;
      index     <= '1;
      sh_modes  <= '0;
      sh_clk    <= 1'b1;
      act_modes <= '0;
      act_clk   <= 1'b1;
    end else if (clr) begin
      lsb_first <= 1'b0;
      index     <= '1;
      sh_modes  <= '0;
      sh_clk    <= 1'b1;
      act_modes <= '0;
      act_clk   <= 1'b1;
    end else begin
      if (wr_stb && hit(wr_addr, A_CFG))   lsb_first <= wr_data[6] | wr_data[1];
      if (wr_stb && hit(wr_addr, A_INDEX)) index     <= wr_data[NUM_CH-1:0];
      if (wr_stb && hit(wr_addr, A_MODES)) sh_modes  <= wr_data[1:0];
      if (wr_stb && hit(wr_addr, A_CLOCK)) sh_clk    <= wr_data[0];
      if (xfer) begin
        act_modes <= sh_modes;
        act_clk   <= sh_clk;
      end
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_test[ch]  <= '0;
        sh_bist[ch]  <= '0;
        act_test[ch] <= '0;
        act_bist[ch] <= '0;
      end else if (clr) begin
        sh_test[ch]  <= '0;
        sh_bist[ch]  <= '0;
        act_test[ch] <= '0;
        act_bist[ch] <= '0;
      end else begin
        if (wr_stb && index[ch] && hit(wr_addr, A_TEST)) sh_test[ch] <= wr_data & TEST_MASK;
        if (wr_stb && index[ch] && hit(wr_addr, A_BIST)) sh_bist[ch] <= wr_data & BIST_MASK;
        if (xfer) begin
          act_test[ch] <= sh_test[ch];
          act_bist[ch] <= sh_bist[ch];
        end
      end
    end
    assign test_cfg[8*ch +: 8] = act_test[ch];
    assign bist_cfg[8*ch +: 8] = act_bist[ch];
  end

  // lowest selected channel wins on read
  always_comb begin
    sel   = '0;
    found = 1'b0;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (index[c]) begin
        sel   = SW'(c);
        found = 1'b1;
      end
    end
  end

  always_comb begin
    rd_data = 8'h00;
    if (hit(rd_addr, A_CFG))   rd_data = {1'b0, lsb_first, 1'b0, 2'b11, 1'b0, lsb_first, 1'b0};
    if (hit(rd_addr, A_ID))    rd_data = ID_VALUE;
    if (hit(rd_addr, A_INDEX)) rd_data = {{(8-NUM_CH){1'b0}}, index};
    if (hit(rd_addr, A_MODES)) rd_data = {6'b0, sh_modes};
    if (hit(rd_addr, A_CLOCK)) rd_data = {7'b0, sh_clk};
    if (hit(rd_addr, A_TEST) && found) rd_data = sh_test[sel];
    if (hit(rd_addr, A_BIST) && found) rd_data = sh_bist[sel];
  end

  assign pwr_mode = act_modes;
  assign dcs_en   = act_clk;

  // R7: active controls hold unless a transfer or soft reset occurs
  p_hold_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer && !clr) |=> ($stable(pwr_mode) && $stable(dcs_en) && $stable(test_cfg) && $stable(bist_cfg)));

  // R7: a transfer copies the shadow values seen in its cycle
  p_xfer_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !clr) |=> (pwr_mode == $past(sh_modes) && dcs_en == $past(sh_clk)));

  // R11: soft reset returns selection, order and controls to defaults
  p_soft_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (index == '1 && !lsb_first && pwr_mode == 2'b00 && dcs_en && test_cfg == '0));
endmodule

// File: rtl/conv_cfg_spi.sv
module conv_cfg_spi #(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sclk,
  input  logic                csb,
  input  logic                sdio_in,
  output logic                sdio_out,
  output logic                sdio_oe,
  output logic [1:0]          pwr_mode,
  output logic                dcs_en,
  output logic [8*NUM_CH-1:0] test_cfg,
  output logic [8*NUM_CH-1:0] bist_cfg
);
  logic [2:0]        pins_s;
  logic              lsb_first, wr_stb;
  logic [7:0]        rd_data, wr_data;
  logic [ADDR_W-1:0] rd_addr, wr_addr;

  conv_cfg_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({sdio_in, csb, sclk}),
    .q(pins_s)
  );

  conv_cfg_frame #(.ADDR_W(ADDR_W)) u_frame (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(pins_s[0]), .csb_s(pins_s[1]), .sdi_s(pins_s[2]),
    .lsb_first(lsb_first),
    .rd_data(rd_data), .rd_addr(rd_addr),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .sdo(sdio_out), .sdo_oe(sdio_oe)
  );

  conv_cfg_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .lsb_first(lsb_first),
    .pwr_mode(pwr_mode), .dcs_en(dcs_en),
    .test_cfg(test_cfg), .bist_cfg(bist_cfg)
  );
endmodule

// File: tb/tb_conv_cfg_spi.sv
`timescale 1ns/1ps
module tb_conv_cfg_spi;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, csb = 1'b1, sdio_in = 1'b0;
  logic sdio_out, sdio_oe, dcs_en;
  logic [1:0] pwr_mode;
  logic [15:0] test_cfg, bist_cfg;
  int n_chk = 0, n_bad = 0;
  bit lsb = 1'b0, done = 1'b0;

  always #10 clk = ~clk;

  conv_cfg_spi dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .csb(csb), .sdio_in(sdio_in),
    .sdio_out(sdio_out), .sdio_oe(sdio_oe), .pwr_mode(pwr_mode),
    .dcs_en(dcs_en), .test_cfg(test_cfg), .bist_cfg(bist_cfg)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic sbit(input logic b, output logic r, output logic oe);
    @(negedge clk); sdio_in = b;
    repeat (HALF) @(negedge clk);
    r = sdio_out; oe = sdio_oe;
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic sword(input logic [15:0] w);
    logic r, oe;
    for (int i = 0; i < 16; i++) sbit(lsb ? w[i] : w[15-i], r, oe);
  endtask

  task automatic sbyte(input logic [7:0] v, output logic [7:0] r, output logic all_oe);
    logic b, oe;
    all_oe = 1'b1;
    for (int i = 0; i < 8; i++) begin
      int idx = lsb ? i : 7 - i;
      sbit(v[idx], b, oe);
      r[idx] = b;
      all_oe &= oe;
    end
  endtask

  task automatic cs_lo();
    @(negedge clk); csb = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_hi();
    repeat (HALF) @(negedge clk);
    csb = 1'b1;
    repeat (4*HALF) @(negedge clk);
  endtask

  task automatic wr1(input logic [12:0] a, input logic [7:0] d);
    logic [7:0] r; logic oe;
    cs_lo(); sword({1'b0, 2'b00, a}); sbyte(d, r, oe); cs_hi();
  endtask

  task automatic rd1(input logic [12:0] a, output logic [7:0] v, output logic oe);
    cs_lo(); sword({1'b1, 2'b00, a}); sbyte(8'h00, v, oe); cs_hi();
  endtask

  task automatic expect_rd(input string tag, input logic [12:0] a, input logic [7:0] e);
    logic [7:0] v; logic oe;
    rd1(a, v, oe);
    check(tag, {8'h00, v}, {8'h00, e});
  endtask

  task automatic t_reset();
    check("R10 reset pwr_mode", {14'b0, pwr_mode}, 16'h0000);
    check("R10 reset dcs_en", {15'b0, dcs_en}, 16'h0001);
    check("R10 reset test_cfg", test_cfg, 16'h0000);
    check("R10 reset bist_cfg", bist_cfg, 16'h0000);
    check("R4 reset sdio_oe", {15'b0, sdio_oe}, 16'h0000);
    expect_rd("R6 default cfg", 13'h000, 8'h18);
    expect_rd("R9 chip id", 13'h001, 8'h0A);
    expect_rd("R9 grade", 13'h002, 8'h00);
    expect_rd("R8 default index", 13'h005, 8'h03);
    expect_rd("R10 default clock", 13'h009, 8'h01);
    expect_rd("R7 xfer reads zero", 13'h0FF, 8'h00);
  endtask

  task automatic t_readonly();
    wr1(13'h001, 8'h55);
    expect_rd("R9 id ignores write", 13'h001, 8'h0A);
    wr1(13'h002, 8'h70);
    expect_rd("R9 grade ignores write", 13'h002, 8'h00);
    wr1(13'h013, 8'hAA);
    expect_rd("R12 unsupported reads zero", 13'h013, 8'h00);
  endtask

  task automatic t_shadow();
    wr1(13'h008, 8'hFD);
    wr1(13'h00D, 8'hFF);
    check("R7 pwr held before xfer", {14'b0, pwr_mode}, 16'h0000);
    check("R7 test held before xfer", test_cfg, 16'h0000);
    expect_rd("R10 modes masked", 13'h008, 8'h01);
    expect_rd("R10 test masked", 13'h00D, 8'h37);
    wr1(13'h0FF, 8'h01);
    check("R7 pwr after xfer", {14'b0, pwr_mode}, 16'h0001);
    check("R7 test after xfer", test_cfg, 16'h3737);
    expect_rd("R7 xfer self-clears", 13'h0FF, 8'h00);
    wr1(13'h008, 8'h00);
    check("R7 pwr holds active", {14'b0, pwr_mode}, 16'h0001);
  endtask

  task automatic t_index();
    wr1(13'h005, 8'h02);
    wr1(13'h00E, 8'hFF);
    expect_rd("R8 index readback", 13'h005, 8'h02);
    expect_rd("R8 read B copy", 13'h00E, 8'h05);
    wr1(13'h005, 8'h01);
    expect_rd("R8 A copy untouched", 13'h00E, 8'h00);
    wr1(13'h00D, 8'h12);
    wr1(13'h009, 8'h00);
    wr1(13'h005, 8'h03);
    expect_rd("R8 both selected reads A", 13'h00D, 8'h12);
    wr1(13'h0FF, 8'h01);
    check("R8 per-channel test", test_cfg, 16'h3712);
    check("R8 per-channel bist", bist_cfg, 16'h0500);
    check("R13 global ignores index", {15'b0, dcs_en}, 16'h0000);
    check("R13 global pwr", {14'b0, pwr_mode}, 16'h0000);
  endtask

  task automatic t_multi();
    logic [7:0] r0, r1; logic oe0, oe1;
    cs_lo(); sword({1'b0, 2'b10, 13'h00E});
    sbyte(8'h04, r0, oe0); sbyte(8'h21, r0, oe0); sbyte(8'h99, r0, oe0);
    cs_hi();
    expect_rd("R5 first byte at start", 13'h00E, 8'h04);
    expect_rd("R5 second byte stepped down", 13'h00D, 8'h21);
    expect_rd("R12 third byte ignored", 13'h00C, 8'h00);
    cs_lo(); sword({1'b1, 2'b01, 13'h00E});
    sbyte(8'h00, r0, oe0); sbyte(8'h00, r1, oe1);
    cs_hi();
    check("R2 burst read byte0", {8'h00, r0}, 16'h0004);
    check("R5 burst read byte1", {8'h00, r1}, 16'h0021);
    check("R4 oe during read data", {15'b0, oe0 & oe1}, 16'h0001);
    check("R4 oe released after frame", {15'b0, sdio_oe}, 16'h0000);
  endtask

  task automatic t_stall();
    logic [7:0] r; logic oe, b;
    cs_lo(); sword({1'b0, 2'b01, 13'h009});
    sbyte(8'h01, r, oe);
    repeat (HALF) @(negedge clk); csb = 1'b1;
    repeat (4*HALF) @(negedge clk);
    cs_lo();
    sbyte(8'h02, r, oe);
    cs_hi();
    expect_rd("R3 byte before stall", 13'h009, 8'h01);
    expect_rd("R3 byte after stall", 13'h008, 8'h02);
    cs_lo(); sword({1'b0, 2'b00, 13'h008});
    for (int i = 0; i < 4; i++) sbit(1'b1, b, oe);
    cs_hi();
    expect_rd("R3 mid-byte abort writes nothing", 13'h008, 8'h02);
  endtask

  task automatic t_stream();
    logic [7:0] r; logic oe;
    cs_lo(); sword({1'b0, 2'b11, 13'h00E});
    sbyte(8'h01, r, oe); sbyte(8'h30, r, oe); sbyte(8'h55, r, oe); sbyte(8'h66, r, oe);
    cs_hi();
    expect_rd("R2 stream byte0", 13'h00E, 8'h01);
    expect_rd("R2 stream byte1", 13'h00D, 8'h30);
  endtask

  task automatic t_lsb();
    logic [7:0] r; logic oe;
    wr1(13'h000, 8'h42);
    lsb = 1'b1;
    expect_rd("R6 mirrored lsb cfg", 13'h000, 8'h5A);
    cs_lo(); sword({1'b0, 2'b01, 13'h008});
    sbyte(8'h03, r, oe); sbyte(8'h01, r, oe);
    cs_hi();
    expect_rd("R5 lsb first byte", 13'h008, 8'h03);
    expect_rd("R5 lsb stepped up", 13'h009, 8'h01);
    wr1(13'h0FF, 8'h01);
    check("R7 pwr after lsb xfer", {14'b0, pwr_mode}, 16'h0003);
    wr1(13'h000, 8'h24);
    lsb = 1'b0;
    check("R11 pwr restored", {14'b0, pwr_mode}, 16'h0000);
    check("R11 test restored", test_cfg, 16'h0000);
    check("R11 dcs restored", {15'b0, dcs_en}, 16'h0001);
    expect_rd("R11 cfg default, bit cleared", 13'h000, 8'h18);
    expect_rd("R11 index default", 13'h005, 8'h03);
    expect_rd("R11 test shadow default", 13'h00D, 8'h00);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_readonly();
    t_shadow();
    t_index();
    t_multi();
    t_stall();
    t_stream();
    t_lsb();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule